// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Dependent Flags and Retransmit

This block is a first-in first-out buffer that sits between two unrelated clock domains. Words enter on the write clock and leave on the read clock. The pointers cross between the domains as Gray codes through a configurable chain of synchronizer flops.

Each side produces its own status flags, timed to its own clock. The write side gives a full/input-ready flag, a half-full flag and a programmable almost-full flag. The read side gives an empty/output-ready flag and a programmable almost-empty flag.

A master reset samples two things: the timing mode (standard or fall-through) and the two threshold offsets. A partial reset clears the contents and leaves both of those settings as they were. An active-low retransmit strobe rewinds the read pointer to the start of memory, so stored words can be read again. An output enable forces the data output to zero without disturbing any state.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `mrst` is high, both pointers are cleared. `fwft_sel` (0 = standard, 1 = fall-through) and the `ae_off`/`af_off` inputs are captured. After reset in standard mode: `empty_or`=1, `full_ir`=0, `almost_empty`=1, `half_full`=0, `almost_full`=0 and `dout`=0.
- R2: While `prst` is high, both pointers are cleared. The mode and offsets captured at the last master reset are kept, and `fwft_sel`, `ae_off` and `af_off` are ignored.
- R3: A write attempted while the memory holds DEPTH words is dropped. Stored contents and order are unchanged.
- R4: In standard mode, a read attempted while empty leaves `dout` and the read pointer unchanged.
- R5: In standard mode, `ren`=1 on a read-clock edge with data present loads the oldest word into `dout` on that edge. Words come out in write order.
- R6: In fall-through mode, the oldest word appears on `dout` with no read request, and `empty_or`=1 marks it valid. `ren`=1 on an edge with a valid word advances to the next word, or drops `empty_or` to 0 if none is left.
- R7: In standard mode, `full_ir`=1 means the memory is full. In fall-through mode, `full_ir`=1 means a write will be accepted, and `full_ir`=0 means full.
- R8: `half_full`=1 exactly when the write-side fill level exceeds DEPTH/2.
- R9: `almost_full`=1 exactly when the write-side fill level is at least DEPTH minus the captured almost-full offset.
- R10: `almost_empty`=1 exactly when the read-side fill level is at most the captured almost-empty offset.
- R11: `rt_n`=0 on a read-clock edge sets the read pointer back to location 0. This is valid while no more than DEPTH words have been written since the last reset. The same words are then read again in the same order.
- R12: With `oe`=0, `dout` is 0. The output register and read pointer are untouched, so the held word returns when `oe` goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, sampled in both domains |
| prst | input | 1 | Partial reset, active high, sampled in both domains |
| fwft_sel | input | 1 | Timing mode captured at master reset (1 = fall-through) |
| ae_off | input | AW+1 | Almost-empty offset captured at master reset |
| af_off | input | AW+1 | Almost-full offset captured at master reset |
| wen | input | 1 | Write request |
| din | input | DW | Write data |
| ren | input | 1 | Read request |
| rt_n | input | 1 | Retransmit, active low |
| oe | input | 1 | Output enable (0 forces `dout` to zero) |
| dout | output | DW | Read data |
| full_ir | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| almost_full | output | 1 | Programmable almost-full flag |
| half_full | output | 1 | Half-full flag |
| empty_or | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| almost_empty | output | 1 | Programmable almost-empty flag |

## Verification
Each error shows up at the ports after a bounded delay:

- **Read-side fill error** (for example a pointer that moved on an ignored read): `empty_or` and `almost_empty` go wrong on the next read-clock edge, and `dout` shows the wrong word on the next read.
- **Write-side fill error**: `full_ir`, `half_full` and `almost_full` go wrong at once in the write domain.
- **Crossing error** (a bad synchronizer or Gray conversion): the error appears on the other side's flags only after the synchronizer depth plus one cycle, so flag checks are sampled after that settling time.
- **Mode or offset lost across a partial reset**: the flags or fall-through behaviour go wrong on the first fill level that crosses a threshold.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } tmode_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wr_flags_t;

    typedef struct packed {
        logic mem_empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_sel,
    input  logic [AW:0]   af_off_in,
    input  logic          wen,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          wr_go,
    output logic          full_ir,
    output logic          almost_full,
    output logic          half_full
);
    localparam int          PW     = AW + 1;
    localparam logic [AW:0] DEPTH_V = PW'(1) << AW;
    localparam logic [AW:0] HALF_V  = PW'(1) << (AW - 1);

    logic        rst;
    tmode_e      mode;
    logic [AW:0] af_off;
    logic [AW:0] wbin, wbin_nx, rbin_s, fill;
    wr_flags_t   fl;

    assign rst = mrst | prst;

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode   <= tmode_e'(fwft_sel);
            af_off <= af_off_in;
        end
    end

    assign rbin_s  = PW'(gray2bin(32'(rgray_s)));
    assign fill    = wbin - rbin_s;
    assign fl.full        = (fill == DEPTH_V);
    assign fl.almost_full = (fill >= (DEPTH_V - af_off));
    assign fl.half_full   = (fill > HALF_V);

    assign wr_go   = wen && !fl.full;
    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin_nx;
            wgray <= PW'(bin2gray(32'(wbin_nx)));
        end
    end

    assign waddr       = wbin[AW-1:0];
    assign full_ir     = (mode == MODE_FWFT) ? !fl.full : fl.full;
    assign almost_full = fl.almost_full;
    assign half_full   = fl.half_full;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (fl.full && wen) |=> $stable(wbin));

    p_mode_kept_r2: assert property (@(posedge clk) disable iff (mrst)
        prst |=> ($stable(mode) && $stable(af_off)));

    p_full_implies_half_r8: assert property (@(posedge clk) disable iff (rst)
        fl.full |-> (fl.half_full && fl.almost_full));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_sel,
    input  logic [AW:0]   ae_off_in,
    input  logic          ren,
    input  logic          rt_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] q,
    output logic          empty_or,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic        rst;
    tmode_e      mode;
    logic [AW:0] ae_off;
    logic [AW:0] rbin, rbin_nx, wbin_s, fill;
    logic        ovalid, take;
    rd_flags_t   fl;

    assign rst = mrst | prst;

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode   <= tmode_e'(fwft_sel);
            ae_off <= ae_off_in;
        end
    end

    assign wbin_s          = PW'(gray2bin(32'(wgray_s)));
    assign fill            = wbin_s - rbin;
    assign fl.mem_empty    = (fill == '0);
    assign fl.almost_empty = (fill <= ae_off);

    always_comb begin
        if (mode == MODE_FWFT) take = !fl.mem_empty && (!ovalid || ren);
        else                   take = ren && !fl.mem_empty;
    end

    assign rbin_nx = rbin + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
            q      <= '0;
        end else if (!rt_n) begin
            rbin   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
        end else if (take) begin
            rbin   <= rbin_nx;
            rgray  <= PW'(bin2gray(32'(rbin_nx)));
            q      <= rd_data;
            ovalid <= 1'b1;
        end else if (ren) begin
            ovalid <= 1'b0;
        end
    end

    assign raddr        = rbin[AW-1:0];
    assign empty_or     = (mode == MODE_FWFT) ? ovalid : fl.mem_empty;
    assign almost_empty = fl.almost_empty;

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD && fl.mem_empty && ren && rt_n) |=> ($stable(rbin) && $stable(q)));

    p_rewind_r11: assert property (@(posedge clk) disable iff (rst)
        !rt_n |=> (rbin == '0));

    p_fwft_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && ovalid && !ren && rt_n) |=> ($stable(q) && ovalid));

    p_empty_in_ae_r10: assert property (@(posedge clk) disable iff (rst)
        fl.mem_empty |-> fl.almost_empty);
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
    import dcf_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          fwft_sel,
    input  logic [AW:0]   ae_off,
    input  logic [AW:0]   af_off,
    input  logic          wen,
    input  logic [DW-1:0] din,
    input  logic          ren,
    input  logic          rt_n,
    input  logic          oe,
    output logic [DW-1:0] dout,
    output logic          full_ir,
    output logic          almost_full,
    output logic          half_full,
    output logic          empty_or,
    output logic          almost_empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wr_go;
    logic [DW-1:0] q;

    always_ff @(posedge wclk) begin
        if (wr_go) mem[waddr] <= din;
    end

    dcf_wr_side #(.AW(AW)) wr_i (
        .clk(wclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
        .af_off_in(af_off), .wen(wen), .rgray_s(rgray_s),
        .wgray(wgray), .waddr(waddr), .wr_go(wr_go),
        .full_ir(full_ir), .almost_full(almost_full), .half_full(half_full)
    );

    dcf_rd_side #(.AW(AW), .DW(DW)) rd_i (
        .clk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
        .ae_off_in(ae_off), .ren(ren), .rt_n(rt_n), .wgray_s(wgray_s),
        .rd_data(mem[raddr]), .rgray(rgray), .raddr(raddr), .q(q),
        .empty_or(empty_or), .almost_empty(almost_empty)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_i (
        .clk(rclk), .rst(mrst | prst), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_i (
        .clk(wclk), .rst(mrst | prst), .d(rgray), .q(rgray_s)
    );

    assign dout = oe ? q : '0;
endmodule

// File: tb/dual_clock_fifo_tb_top.sv
module dual_clock_fifo_tb_top;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
    logic [AW:0]   ae_off = 5'd3, af_off = 5'd3;
    logic          wen = 1'b0, ren = 1'b0, rt_n = 1'b1, oe = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full_ir, almost_full, half_full, empty_or, almost_empty;

    int checks = 0;
    int fails  = 0;

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #10 rclk = ~rclk;
    end

    dual_clock_fifo #(.DW(DW), .AW(AW)) dut_i (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
        .ae_off(ae_off), .af_off(af_off), .wen(wen), .din(din), .ren(ren),
        .rt_n(rt_n), .oe(oe), .dout(dout), .full_ir(full_ir),
        .almost_full(almost_full), .half_full(half_full),
        .empty_or(empty_or), .almost_empty(almost_empty)
    );

    // Vector fields: [10:5] words written, [4] empty_or, [3] almost_empty,
    // [2] half_full, [1] almost_full, [0] full_ir (standard mode, offsets 3/3).
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {6'd0,  5'b11000}, {6'd1,  5'b01000}, {6'd3,  5'b01000},
        {6'd4,  5'b00000}, {6'd8,  5'b00000}, {6'd9,  5'b00100},
        {6'd12, 5'b00100}, {6'd13, 5'b00110}, {6'd16, 5'b00111},
        {6'd19, 5'b00111}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic master, input logic mode,
                            input logic [AW:0] aoff, input logic [AW:0] foff);
        @(negedge wclk);
        mrst = master; prst = !master; fwft_sel = mode; ae_off = aoff; af_off = foff;
        repeat (4) @(negedge wclk);
        mrst = 1'b0; prst = 1'b0;
        repeat (4) @(negedge wclk);
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        #1;
    endtask

    task automatic wr_burst(input int n, input logic [DW-1:0] base);
        for (int k = 0; k < n; k++) begin
            @(negedge wclk);
            wen = 1'b1; din = base + DW'(k);
        end
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic rd_one(output logic [DW-1:0] d);
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        #1;
        d = dout;
    endtask

    initial begin
        logic [DW-1:0] d;
        // R1: master reset, standard mode, offsets 3/3
        do_reset(1'b1, 1'b0, 5'd3, 5'd3);
        settle();
        check("R1 empty_or", 32'(empty_or), 32'd1);
        check("R1 full_ir", 32'(full_ir), 32'd0);
        check("R1 almost_empty", 32'(almost_empty), 32'd1);
        check("R1 half_full", 32'(half_full), 32'd0);
        check("R1 almost_full", 32'(almost_full), 32'd0);
        check("R1 dout", 32'(dout), 32'd0);

        // Table walk: partial reset with different mode/offset inputs each time (R2)
        for (int v = 0; v < NV; v++) begin
            do_reset(1'b0, 1'b1, 5'd7, 5'd7);
            wr_burst(int'(VEC[v][10:5]), 8'h00);
            settle();
            check("R2/R7 empty_or", 32'(empty_or), 32'(VEC[v][4]));
            check("R10 almost_empty", 32'(almost_empty), 32'(VEC[v][3]));
            check("R8 half_full", 32'(half_full), 32'(VEC[v][2]));
            check("R9 almost_full", 32'(almost_full), 32'(VEC[v][1]));
            check("R3/R7 full_ir", 32'(full_ir), 32'(VEC[v][0]));
        end

        // R3/R5: after 19 attempted writes, exactly 16 words in order
        for (int k = 0; k < 16; k++) begin
            rd_one(d);
            check("R5 order", 32'(d), 32'(k));
        end
        check("R3 empty after 16", 32'(empty_or), 32'd1);

        // R4: read while empty leaves dout and pointer
        rd_one(d);
        check("R4 dout held", 32'(d), 32'd15);
        wr_burst(1, 8'hA5);
        settle();
        rd_one(d);
        check("R4 pointer unmoved", 32'(d), 32'hA5);

        // R11: retransmit
        do_reset(1'b0, 1'b0, 5'd3, 5'd3);
        wr_burst(3, 8'h10);
        settle();
        for (int k = 0; k < 3; k++) rd_one(d);
        check("R11 drained", 32'(empty_or), 32'd1);
        @(negedge rclk); rt_n = 1'b0;
        @(negedge rclk); rt_n = 1'b1;
        settle();
        check("R11 data again", 32'(empty_or), 32'd0);
        for (int k = 0; k < 3; k++) begin
            rd_one(d);
            check("R11 replay", 32'(d), 32'h10 + 32'(k));
        end

        // R12: output enable
        do_reset(1'b0, 1'b0, 5'd3, 5'd3);
        wr_burst(2, 8'h21);
        settle();
        rd_one(d);
        check("R12 first", 32'(d), 32'h21);
        @(negedge rclk); oe = 1'b0;
        repeat (3) @(negedge rclk);
        #1;
        check("R12 zero", 32'(dout), 32'd0);
        @(negedge rclk); oe = 1'b1;
        #1;
        check("R12 held", 32'(dout), 32'h21);
        rd_one(d);
        check("R12 pointer", 32'(d), 32'h22);

        // R6/R7: fall-through mode via master reset
        do_reset(1'b1, 1'b1, 5'd2, 5'd2);
        settle();
        check("R7 fwft ready", 32'(full_ir), 32'd1);
        check("R6 no word", 32'(empty_or), 32'd0);
        check("R10 fwft ae", 32'(almost_empty), 32'd1);
        wr_burst(1, 8'h31);
        settle();
        check("R6 fell through", 32'(empty_or), 32'd1);
        check("R6 data", 32'(dout), 32'h31);
        wr_burst(1, 8'h32);
        settle();
        check("R6 held without ren", 32'(dout), 32'h31);
        rd_one(d);
        check("R6 advance", 32'(d), 32'h32);
        check("R6 still valid", 32'(empty_or), 32'd1);
        rd_one(d);
        check("R6 consumed", 32'(empty_or), 32'd0);

        // R2: partial reset keeps fall-through mode
        do_reset(1'b0, 1'b0, 5'd3, 5'd3);
        wr_burst(1, 8'h44);
        settle();
        check("R2 mode kept", 32'(empty_or), 32'd1);
        check("R2 mode kept data", 32'(dout), 32'h44);
        wr_burst(20, 8'h50);
        settle();
        check("R7 fwft full", 32'(full_ir), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wclk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule